// File: doc/BRIEF.md
# Banked Gamma Correction Lookup Unit

This block applies gamma correction to a stream of RGB pixels. Each 10-bit input component indexes its own 1024-entry table, and the block returns a 12-bit corrected code for each one. Tables are loaded over a simple 32-bit register bus through a window of 256 words. A bank register picks which quarter of the table the window reaches.

Table words come in one of two layouts. In the packed 10-bit layout, one word carries all three components. In the split 12-bit layout, a primary window carries red and green, and a second window carries blue. The tables can also be loaded in a differential form, where odd entries are offsets from the even entry before them. The block turns these offsets back into absolute codes when they are written, so the lookup path always reads finished values.

The pixel path is a single register stage with a valid/ready handshake on both sides. Start-of-frame and end-of-line markers travel with each pixel. A line-length monitor compares each line against the programmed horizontal size and latches a sticky error.

Top module: `gamma_lut_unit`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and reads of the enable (0x000), configuration (0x020) and status (0x040) registers return 0.
- R2: These registers read back as written with a one-cycle read latency:
  - enable at 0x000, bit 0;
  - configuration at 0x020, bits 3:0 (bit 0 relay, bit 1 table enable, bit 2 descending, bit 3 differential);
  - size at 0x030 (horizontal size in bits 28:16, vertical size in bits 12:0);
  - bank at 0x100 (bank in bits 1:0, 12-bit layout flag in bit 2).
- R3: When enable bit 0 is clear, each output component equals the input component shifted left by two (input in bits 11:2, zeros in bits 1:0).
- R4: When the relay bit is set or the table-enable bit is clear, pixels pass through as in R3, with the same one-stage latency as a lookup.
- R5: With bank bit 2 clear, a write to 0x700+4*i stores entry bank*256+i. Red comes from bits 29:20, green from 19:10 and blue from 9:0. A looked-up entry is output as the 10-bit code shifted left by two.
- R6: With bank bit 2 set, a write to 0x700+4*i stores red from bits 11:0 and green from 23:12. A write to 0xB00+4*i stores blue from bits 11:0, and entries are output unshifted. With bank bit 2 clear, writes to the 0xB00 window change nothing.
- R7: Each input component indexes its own table independently with its full 10-bit value.
- R8: With configuration bit 3 set, a write to an odd index stores, for each component, the most recent even-index value written plus the written delta. The sum is clamped to the maximum code: 1023 in the 10-bit layout, 4095 in the 12-bit layout. Even-index writes store absolute values.
- R9: With configuration bits 3 and 2 both set, an odd-index write stores the previous even value minus the delta, clamped at 0.
- R10: in_ready is high when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the output data and markers hold steady, and start-of-frame and end-of-line appear with their own pixel.
- R11: Status bit 0 (0x040) sets when an end-of-line pixel's position in its line differs from the horizontal size, or when the pixel at that position lacks end-of-line. A pixel carrying start-of-frame counts as position 1. The bit stays set until software writes 1 to status bit 0.
- R12: A pixel accepted on a clock edge shows up at the outputs with out_valid high right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when valid |
| in_sof | input | 1 | Input start of frame |
| in_eol | input | 1 | Input end of line |
| in_r | input | 10 | Input red |
| in_g | input | 10 | Input green |
| in_b | input | 10 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_sof | output | 1 | Output start of frame |
| out_eol | output | 1 | Output end of line |
| out_r | output | 12 | Output red |
| out_g | output | 12 | Output green |
| out_b | output | 12 | Output blue |

## Verification
The lookup is checked in four ways:
- **Equal components across all four banks and at both window ends.** Each pixel has all three components set to the same value. This tells apart the bank decode and the per-component field placement.
- **Different components in one pixel.** A pixel whose three components differ shows that the three tables are indexed independently.
- **Differential entries in both layouts.** Deltas are chosen so that one component stays in range, one clamps at the top and, in descending mode, one clamps at zero. This tells the saturation logic apart from plain addition.
- **Bypass routes and line lengths.** Passthrough is tried through each of its three routes. Lines that are too short, correct, and missing their end-of-line separate the set, hold and clear behaviour of the line check.

// File: rtl/gamma_lut_unit.sv
module gamma_lut_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sof,
  input  logic        in_eol,
  input  logic [9:0]  in_r,
  input  logic [9:0]  in_g,
  input  logic [9:0]  in_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_sof,
  output logic        out_eol,
  output logic [11:0] out_r,
  output logic [11:0] out_g,
  output logic [11:0] out_b
);
  localparam int ENTRIES = 1024;
  localparam logic [11:0] A_EN   = 12'h000;
  localparam logic [11:0] A_CFG  = 12'h020;
  localparam logic [11:0] A_SIZE = 12'h030;
  localparam logic [11:0] A_STAT = 12'h040;
  localparam logic [11:0] A_BANK = 12'h100;

  logic        en_q, err_q;
  logic [3:0]  cfg_q;
  logic [2:0]  bank_q;
  logic [12:0] hsz_q, vsz_q, cnt_q;
  logic [11:0] ev_r, ev_g, ev_b;
  logic [11:0] lut_r [ENTRIES];
  logic [11:0] lut_g [ENTRIES];
  logic [11:0] lut_b [ENTRIES];

  wire aligned = (reg_addr[1:0] == 2'b00);
  wire win0 = aligned && reg_addr >= 12'h700 && reg_addr < 12'hB00;
  wire win1 = aligned && reg_addr >= 12'hB00 && reg_addr < 12'hF00;
  wire m12  = bank_q[2];
  wire [7:0] wr_idx = reg_addr[9:2] - 8'hC0;
  wire [9:0] wr_ent = {bank_q[1:0], wr_idx};
  wire we_rg = reg_wr && win0;
  wire we_b  = reg_wr && (m12 ? win1 : win0);
  wire apply = cfg_q[3] && wr_idx[0];

  wire [11:0] raw_r = m12 ? reg_wdata[11:0]  : {2'b00, reg_wdata[29:20]};
  wire [11:0] raw_g = m12 ? reg_wdata[23:12] : {2'b00, reg_wdata[19:10]};
  wire [11:0] raw_b = m12 ? reg_wdata[11:0]  : {2'b00, reg_wdata[9:0]};

  function automatic logic [11:0] rebuild(logic [11:0] prev, logic [11:0] raw,
                                          logic odd_delta, logic desc, logic wide);
    logic [12:0] p, d, s, mx;
    p  = wide ? {1'b0, prev} : {3'b000, prev[11:2]};
    d  = {1'b0, raw};
    mx = wide ? 13'd4095 : 13'd1023;
    if (!odd_delta)  s = d;
    else if (desc)   s = (d > p) ? 13'd0 : p - d;
    else begin
      s = p + d;
      if (s > mx) s = mx;
    end
    return wide ? s[11:0] : {s[9:0], 2'b00};
  endfunction

  wire [11:0] st_r = rebuild(ev_r, raw_r, apply, cfg_q[2], m12);
  wire [11:0] st_g = rebuild(ev_g, raw_g, apply, cfg_q[2], m12);
  wire [11:0] st_b = rebuild(ev_b, raw_b, apply, cfg_q[2], m12);

  assign in_ready = !out_valid || out_ready;
  wire acc    = in_valid && in_ready;
  wire bypass = !en_q || cfg_q[0] || !cfg_q[1];
  wire [12:0] pos = in_sof ? 13'd1 : cnt_q + 13'd1;
  wire mismatch = in_eol != (pos == hsz_q);
  wire clr = reg_wr && reg_addr == A_STAT && reg_wdata[0];

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[31:30], reg_addr[11:10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; cfg_q <= '0; bank_q <= '0; hsz_q <= '0; vsz_q <= '0;
      err_q <= 1'b0; cnt_q <= '0; reg_rdata <= '0; out_valid <= 1'b0;
      out_sof <= 1'b0; out_eol <= 1'b0;
      ev_r <= '0; ev_g <= '0; ev_b <= '0;
    end else begin
      if (reg_wr && reg_addr == A_EN)   en_q   <= reg_wdata[0];
      if (reg_wr && reg_addr == A_CFG)  cfg_q  <= reg_wdata[3:0];
      if (reg_wr && reg_addr == A_BANK) bank_q <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_SIZE) begin
        hsz_q <= reg_wdata[28:16];
        vsz_q <= reg_wdata[12:0];
      end
      if (we_rg && !wr_idx[0]) begin ev_r <= st_r; ev_g <= st_g; end
      if (we_b && !wr_idx[0]) ev_b <= st_b;
      if (reg_rd) begin
        case (reg_addr)
          A_EN:    reg_rdata <= {31'b0, en_q};
          A_CFG:   reg_rdata <= {28'b0, cfg_q};
          A_SIZE:  reg_rdata <= {3'b0, hsz_q, 3'b0, vsz_q};
          A_STAT:  reg_rdata <= {31'b0, err_q};
          A_BANK:  reg_rdata <= {29'b0, bank_q};
          default: reg_rdata <= '0;
        endcase
      end
      if (acc) begin
        cnt_q <= in_eol ? 13'd0 : pos;
        out_sof <= in_sof;
        out_eol <= in_eol;
      end
      if (acc && mismatch) err_q <= 1'b1;
      else if (clr)        err_q <= 1'b0;
      if (acc)            out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (we_rg) begin
      lut_r[wr_ent] <= st_r;
      lut_g[wr_ent] <= st_g;
    end
    if (we_b) lut_b[wr_ent] <= st_b;
    if (acc) begin
      out_r <= bypass ? {in_r, 2'b00} : lut_r[in_r];
      out_g <= bypass ? {in_g, 2'b00} : lut_g[in_g];
      out_b <= bypass ? {in_b, 2'b00} : lut_b[in_b];
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g)
      && $stable(out_b) && $stable(out_sof) && $stable(out_eol));

  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (!en_q || cfg_q[0] || !cfg_q[1])
      |=> out_r == {$past(in_r), 2'b00} && out_b == {$past(in_b), 2'b00});

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr |=> err_q);
endmodule

// File: tb/gamma_lut_unit_tb_top.sv
`timescale 1ns/1ps
module gamma_lut_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_valid = 0, in_ready, in_sof = 0, in_eol = 0;
  logic [9:0] in_r = '0, in_g = '0, in_b = '0;
  logic out_valid, out_ready = 1'b1, out_sof, out_eol;
  logic [11:0] out_r, out_g, out_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gamma_lut_unit dut_i (.*);

  // {bank[2], index[8], red[10], green[10], blue[10]}
  localparam logic [39:0] VEC [6] = '{
    {2'd0, 8'd0,   10'h000, 10'h001, 10'h002},
    {2'd0, 8'd255, 10'h3FF, 10'h200, 10'h155},
    {2'd1, 8'd7,   10'h123, 10'h045, 10'h3AB},
    {2'd2, 8'd128, 10'h2AA, 10'h155, 10'h0F0},
    {2'd3, 8'd255, 10'h001, 10'h3FE, 10'h3FF},
    {2'd3, 8'd0,   10'h0C3, 10'h30C, 10'h0A5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pix(input logic [9:0] r, g, b, input logic s, e);
    @(negedge clk); in_valid = 1; in_r = r; in_g = g; in_b = b; in_sof = s; in_eol = e;
    @(negedge clk); in_valid = 0; in_sof = 0; in_eol = 0;
  endtask

  task automatic chk_px(input string tag, input logic [11:0] r, g, b);
    chk({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    chk({tag, " red"}, {20'b0, out_r}, {20'b0, r});
    chk({tag, " green"}, {20'b0, out_g}, {20'b0, g});
    chk({tag, " blue"}, {20'b0, out_b}, {20'b0, b});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [39:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    chk("R1 out_valid", {31'b0, out_valid}, 0);
    chk("R1 in_ready", {31'b0, in_ready}, 1);
    rreg(12'h000, rd); chk("R1 enable", rd, 0);
    rreg(12'h020, rd); chk("R1 config", rd, 0);
    rreg(12'h040, rd); chk("R1 status", rd, 0);

    wreg(12'h000, 32'h1);         rreg(12'h000, rd); chk("R2 enable", rd, 32'h1);
    wreg(12'h020, 32'hFFFF_FFFA); rreg(12'h020, rd); chk("R2 config", rd, 32'hA);
    wreg(12'h030, 32'h0780_0438); rreg(12'h030, rd); chk("R2 size", rd, 32'h0780_0438);
    wreg(12'h100, 32'h7);         rreg(12'h100, rd); chk("R2 bank", rd, 32'h7);
    wreg(12'h030, 32'h0);
    wreg(12'h020, 32'h2);

    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      wreg(12'h100, {30'b0, v[39:38]});
      wreg(12'h700 + {2'b00, v[37:30], 2'b00}, {2'b00, v[29:0]});
      pix(v[39:30], v[39:30], v[39:30], 0, 0);
      chk_px($sformatf("R5 vector %0d", k), {v[29:20], 2'b00}, {v[19:10], 2'b00}, {v[9:0], 2'b00});
    end

    pix(10'h107, 10'h000, 10'h3FF, 0, 0);
    chk_px("R7 mixed", 12'h48C, 12'h004, 12'hFFC);

    wreg(12'h000, 32'h0);
    pix(10'h107, 10'h2AA, 10'h001, 0, 0);
    chk_px("R3 disabled", 12'h41C, 12'hAA8, 12'h004);
    wreg(12'h000, 32'h1);
    wreg(12'h020, 32'h3);
    pix(10'h107, 10'h2AA, 10'h001, 0, 0);
    chk_px("R4 relay", 12'h41C, 12'hAA8, 12'h004);
    wreg(12'h020, 32'h0);
    pix(10'h3FF, 10'h000, 10'h155, 0, 0);
    chk_px("R4 table off", 12'hFFC, 12'h000, 12'h554);
    wreg(12'h020, 32'h2);
    pix(10'h107, 10'h000, 10'h3FF, 0, 0);
    chk_px("R4 table back on", 12'h48C, 12'h004, 12'hFFC);

    wreg(12'h100, 32'h6);
    wreg(12'h714, {8'h00, 12'hABC, 12'h123});
    wreg(12'hB14, 32'h0000_0FED);
    pix(10'h205, 10'h205, 10'h205, 0, 0);
    chk_px("R6 split layout", 12'h123, 12'hABC, 12'hFED);

    wreg(12'h020, 32'hA);
    wreg(12'h728, {8'h00, 12'hFF0, 12'h100});
    wreg(12'hB28, 32'h800);
    wreg(12'h72C, {8'h00, 12'h020, 12'h010});
    wreg(12'hB2C, 32'h001);
    pix(10'h20A, 10'h20A, 10'h20A, 0, 0);
    chk_px("R8 12b even", 12'h100, 12'hFF0, 12'h800);
    pix(10'h20B, 10'h20B, 10'h20B, 0, 0);
    chk_px("R8 12b odd clamp", 12'h110, 12'hFFF, 12'h801);

    wreg(12'h100, 32'h1);
    wreg(12'h750, {2'b00, 10'h3F0, 10'h010, 10'h200});
    wreg(12'h754, {2'b00, 10'h020, 10'h005, 10'h000});
    pix(10'h114, 10'h114, 10'h114, 0, 0);
    chk_px("R8 10b even", 12'hFC0, 12'h040, 12'h800);
    pix(10'h115, 10'h115, 10'h115, 0, 0);
    chk_px("R8 10b odd clamp", 12'hFFC, 12'h054, 12'h800);

    wreg(12'hB50, 32'h123);
    pix(10'h114, 10'h114, 10'h114, 0, 0);
    chk_px("R6 second window ignored in 10b", 12'hFC0, 12'h040, 12'h800);

    wreg(12'h020, 32'hE);
    wreg(12'h778, {2'b00, 10'h100, 10'h005, 10'h3FF});
    wreg(12'h77C, {2'b00, 10'h010, 10'h010, 10'h001});
    pix(10'h11F, 10'h11F, 10'h11F, 0, 0);
    chk_px("R9 descending", 12'h3C0, 12'h000, 12'hFF8);

    wreg(12'h000, 32'h0);
    @(negedge clk); out_ready = 0;
    pix(10'h011, 10'h022, 10'h033, 1, 1);
    chk("R12 valid after accept", {31'b0, out_valid}, 1);
    chk("R10 ready low while stalled", {31'b0, in_ready}, 0);
    repeat (2) @(negedge clk);
    chk_px("R10 held", 12'h044, 12'h088, 12'h0CC);
    chk("R10 sof held", {31'b0, out_sof}, 1);
    chk("R10 eol held", {31'b0, out_eol}, 1);
    out_ready = 1;
    @(negedge clk);
    chk("R10 drained", {31'b0, out_valid}, 0);

    wreg(12'h000, 32'h1);
    wreg(12'h030, {3'b0, 13'd4, 16'h0});
    wreg(12'h040, 32'h1);
    rreg(12'h040, rd); chk("R11 cleared", rd, 0);
    for (int p = 0; p < 4; p++) pix(10'h0, 10'h0, 10'h0, p == 0, p == 3);
    rreg(12'h040, rd); chk("R11 good line", rd, 0);
    for (int p = 0; p < 3; p++) pix(10'h0, 10'h0, 10'h0, p == 0, p == 2);
    rreg(12'h040, rd); chk("R11 short line", rd, 1);
    for (int p = 0; p < 4; p++) pix(10'h0, 10'h0, 10'h0, p == 0, p == 3);
    rreg(12'h040, rd); chk("R11 sticky", rd, 1);
    wreg(12'h040, 32'h1);
    rreg(12'h040, rd); chk("R11 clear", rd, 0);
    for (int p = 0; p < 4; p++) pix(10'h0, 10'h0, 10'h0, p == 0, 0);
    rreg(12'h040, rd); chk("R11 missing eol", rd, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule